// File: doc/BRIEF.md
# SPI Addressed Register Slave

This block is the serial front end of a port-expander: it receives SPI mode 0 frames and turns them into reads and writes of an eleven-entry, 8-bit register file, whose contents drive a separate port block. Up to eight such slaves may share one chip select. Each frame opens with an opcode byte. That byte holds a fixed upper nibble of 0x4, a 3-bit device address in bits 3..1 and a direction bit in bit 0. The second byte sets the register pointer, and every byte after it is data.

The SPI pins are oversampled by the system clock through synchronizers, so the whole block lives in one clock domain. A configuration register selects whether the device address is compared against the strap inputs, and whether the pointer advances after each data byte. The port block supplies the flag, capture and port values that a read of the corresponding read-only entries returns.

Top module: `xp_spi_regs`

## Requirements
- R1: After reset the direction entry (index 0, `dir_o`) reads 0xFF, every other writable entry reads 0x00, and `miso_oe_o` is low.
- R2: A write frame with opcode 0x40 | (addr<<1), followed by the register index and data bytes, stores each data byte at the pointer. The register outputs change only when a data byte completes.
- R3: A read frame (opcode bit 0 = 1) shifts the addressed entry out on `miso_o` MSB first. The first bit is valid before the first rising SCLK edge of the data byte, later bits change after falling edges, and `miso_oe_o` is high for the whole data phase.
- R4: When configuration bit 5 is clear, the pointer advances by one after every data byte, and from index 0x0A or above it wraps to 0x00.
- R5: When configuration bit 5 is set, the pointer stays fixed: repeated writes land on one entry and repeated reads return one entry.
- R6: When configuration bit 3 is set, only frames whose opcode bits 3..1 equal `hw_addr_i` are accepted. When it is clear, those bits are ignored.
- R7: A frame whose upper opcode nibble is not 0x4, or whose address fails a required match, changes no register, and `miso_oe_o` stays low until chip select rises.
- R8: Writes to indices 0x07 and 0x08 are dropped, and a write to index 0x09 updates the output latch (index 0x0A, `olat_o`).
- R9: Reads of indices 0x07, 0x08 and 0x09 return `flag_i`, `cap_i` and `port_i`.
- R10: A pointer above 0x0A reads 0x00, ignores writes, and advances to 0x00.
- R11: `miso_oe_o` is low while chip select is high and during the opcode and index bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock (mode 0) |
| csn_i | input | 1 | Shared active-low chip select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Drive enable for `miso_o`; low means high impedance |
| hw_addr_i | input | 3 | Strapped device address |
| flag_i | input | 8 | Interrupt flag value from the port block |
| cap_i | input | 8 | Interrupt capture value from the port block |
| port_i | input | 8 | Pin level value from the port block |
| dir_o | output | 8 | Direction entry |
| pol_o | output | 8 | Input polarity entry |
| ien_o | output | 8 | Interrupt enable entry |
| cmpv_o | output | 8 | Default compare value entry |
| ictl_o | output | 8 | Interrupt control entry |
| cfg_o | output | 8 | Configuration entry (bit 3 address match, bit 5 hold pointer) |
| pu_o | output | 8 | Pull-up entry |
| olat_o | output | 8 | Output latch entry |

## Verification
SCLK and MOSI pass through two synchronizer stages and an edge detector. A register output therefore changes on the third clock after the SCLK rise that completes a data byte, and `miso_o` moves on the third clock after a falling SCLK edge. The bench holds each SCLK phase for six clocks, samples `miso_o` and `miso_oe_o` on the clock just before it raises SCLK, and checks register outputs eight clocks after chip select rises, so every result has settled. A reference model of the register file and pointer predicts every read byte and output value. It is driven over start indices 0 to 12, all eight opcode addresses and several bad prefixes.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int HWA_W  = 3;
  localparam int NREG   = 11;
  localparam int LAST_IX = NREG - 1;

  localparam int IX_DIR  = 0;
  localparam int IX_POL  = 1;
  localparam int IX_IEN  = 2;
  localparam int IX_CMP  = 3;
  localparam int IX_ICTL = 4;
  localparam int IX_CFG  = 5;
  localparam int IX_PU   = 6;
  localparam int IX_FLAG = 7;
  localparam int IX_CAP  = 8;
  localparam int IX_PORT = 9;
  localparam int IX_OLAT = 10;

  localparam int CFG_ADDR_EN_BIT = 3;
  localparam int CFG_HOLD_BIT    = 5;

  localparam logic [3:0] OPC_PREFIX = 4'h4;

  typedef enum logic [2:0] {ST_OPC, ST_ADR, ST_WR, ST_RD, ST_IGN} fstate_e;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xp_spi_pins.sv
module xp_spi_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic csn_o,
  output logic mosi_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic            sclk_d;

  assign pin_raw = {mosi_i, sclk_i, csn_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    xp_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(i == 0)
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[i]),
      .q_o   (pin_s[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= pin_s[1];
  end

  assign csn_o  = pin_s[0];
  assign mosi_o = pin_s[2];
  assign rise_o = pin_s[1] & ~sclk_d & ~pin_s[0];
  assign fall_o = ~pin_s[1] & sclk_d & ~pin_s[0];
endmodule

// File: rtl/xp_frame_ctrl.sv
module xp_frame_ctrl
  import xp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  input  logic [HWA_W-1:0] hw_addr_i,
  input  logic             addr_en_i,
  input  logic             hold_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic [AW-1:0]    rd_idx_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_idx_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [AW-1:0]    ptr_o,
  output logic             data_byte_o,
  output logic             ign_o,
  output logic             miso_o,
  output logic             miso_oe_o
);
  localparam int BCW = $clog2(DW);

  fstate_e        state_q;
  logic           is_rd_q;
  logic [BCW-1:0] bit_q;
  logic [DW-1:0]  rx_q, tx_q, rx_nxt;
  logic [AW-1:0]  ptr_q;
  logic           byte_done, opc_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic hold);
    if (hold)                 return p;
    if (p >= AW'(LAST_IX))    return '0;
    return p + 1'b1;
  endfunction

  assign rx_nxt    = {rx_q[DW-2:0], mosi_i};
  assign byte_done = rise_i && (bit_q == BCW'(DW - 1));
  assign opc_ok    = (rx_nxt[7:4] == OPC_PREFIX) &&
                     (!addr_en_i || (rx_nxt[3:1] == hw_addr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      is_rd_q <= 1'b0;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
    end else if (csn_i) begin
      state_q <= ST_OPC;
      bit_q   <= '0;
      tx_q    <= '0;
    end else begin
      if (rise_i) begin
        rx_q  <= rx_nxt;
        bit_q <= bit_q + 1'b1;
      end
      if (byte_done) begin
        unique case (state_q)
          ST_OPC: begin
            is_rd_q <= rx_nxt[0];
            state_q <= opc_ok ? ST_ADR : ST_IGN;
          end
          ST_ADR: begin
            if (is_rd_q) begin
              tx_q    <= rd_data_i;
              ptr_q   <= step(rx_nxt, hold_i);
              state_q <= ST_RD;
            end else begin
              ptr_q   <= rx_nxt;
              state_q <= ST_WR;
            end
          end
          ST_WR: ptr_q <= step(ptr_q, hold_i);
          ST_RD: begin
            tx_q  <= rd_data_i;
            ptr_q <= step(ptr_q, hold_i);
          end
          default: ;
        endcase
      end else if (fall_i && (bit_q != '0)) begin
        // bit count zero marks the fall right after a load: keep the MSB
        tx_q <= {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  assign rd_idx_o    = (state_q == ST_ADR) ? rx_nxt : ptr_q;
  assign wr_en_o     = byte_done && (state_q == ST_WR);
  assign wr_idx_o    = ptr_q;
  assign wr_data_o   = rx_nxt;
  assign ptr_o       = ptr_q;
  assign data_byte_o = byte_done && ((state_q == ST_WR) || (state_q == ST_RD));
  assign ign_o       = (state_q == ST_IGN);
  assign miso_o      = tx_q[DW-1];
  assign miso_oe_o   = (state_q == ST_RD);
endmodule

// File: rtl/xp_reg_file.sv
module xp_reg_file
  import xp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_idx_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [AW-1:0]            rd_idx_i,
  output logic [DW-1:0]            rd_data_o,
  input  logic [DW-1:0]            flag_i,
  input  logic [DW-1:0]            cap_i,
  input  logic [DW-1:0]            port_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  logic [AW-1:0] wr_tgt;

  // port index aliases the output latch on writes
  assign wr_tgt = (wr_idx_i == AW'(IX_PORT)) ? AW'(IX_OLAT) : wr_idx_i;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == IX_FLAG) begin : g_flag
      assign regs_o[i] = flag_i;
    end else if (i == IX_CAP) begin : g_cap
      assign regs_o[i] = cap_i;
    end else if (i == IX_PORT) begin : g_port
      assign regs_o[i] = port_i;
    end else begin : g_rw
      localparam logic [DW-1:0] RV = (i == IX_DIR) ? {DW{1'b1}} : {DW{1'b0}};
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= RV;
        else if (wr_en_i && (wr_tgt == AW'(i)))   q <= wr_data_i;
      end
      assign regs_o[i] = q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx_i == AW'(i)) rd_data_o = regs_o[i];
    end
  end
endmodule

// File: rtl/xp_spi_regs.sv
module xp_spi_regs
  import xp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic [HWA_W-1:0] hw_addr_i,
  input  logic [DW-1:0]    flag_i,
  input  logic [DW-1:0]    cap_i,
  input  logic [DW-1:0]    port_i,
  output logic [DW-1:0]    dir_o,
  output logic [DW-1:0]    pol_o,
  output logic [DW-1:0]    ien_o,
  output logic [DW-1:0]    cmpv_o,
  output logic [DW-1:0]    ictl_o,
  output logic [DW-1:0]    cfg_o,
  output logic [DW-1:0]    pu_o,
  output logic [DW-1:0]    olat_o
);
  logic                    csn_s, mosi_s, rise, fall;
  logic [AW-1:0]           rd_idx, wr_idx, ptr;
  logic [DW-1:0]           rd_data, wr_data;
  logic                    wr_en, data_byte, ign;
  logic [NREG-1:0][DW-1:0] regs;

  xp_spi_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(sclk_i),
    .csn_i (csn_i),
    .mosi_i(mosi_i),
    .csn_o (csn_s),
    .mosi_o(mosi_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  xp_frame_ctrl u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .csn_i      (csn_s),
    .mosi_i     (mosi_s),
    .hw_addr_i  (hw_addr_i),
    .addr_en_i  (regs[IX_CFG][CFG_ADDR_EN_BIT]),
    .hold_i     (regs[IX_CFG][CFG_HOLD_BIT]),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .ptr_o      (ptr),
    .data_byte_o(data_byte),
    .ign_o      (ign),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
  );

  xp_reg_file u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data),
    .flag_i   (flag_i),
    .cap_i    (cap_i),
    .port_i   (port_i),
    .regs_o   (regs)
  );

  assign dir_o  = regs[IX_DIR];
  assign pol_o  = regs[IX_POL];
  assign ien_o  = regs[IX_IEN];
  assign cmpv_o = regs[IX_CMP];
  assign ictl_o = regs[IX_ICTL];
  assign cfg_o  = regs[IX_CFG];
  assign pu_o   = regs[IX_PU];
  assign olat_o = regs[IX_OLAT];
endmodule

// File: rtl/xp_spi_regs_chk.sv
module xp_spi_regs_chk
  import xp_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            csn_s,
  input logic            miso_oe_o,
  input logic            data_byte,
  input logic            ign,
  input logic [AW-1:0]   ptr,
  input logic [DW-1:0]   cfg_o,
  input logic [8*DW-1:0] wr_regs
);
  AST_OE_OFF_WITH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> !miso_oe_o); // R11

  AST_REGS_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_byte |=> $stable(wr_regs)); // R2

  AST_IGN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign |=> $stable(wr_regs)); // R7

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_byte && !cfg_o[CFG_HOLD_BIT] && (ptr == AW'(LAST_IX))) |=> (ptr == '0)); // R4

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_byte && cfg_o[CFG_HOLD_BIT]) |=> $stable(ptr)); // R5
endmodule

bind xp_spi_regs xp_spi_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csn_s    (csn_s),
  .miso_oe_o(miso_oe_o),
  .data_byte(data_byte),
  .ign      (ign),
  .ptr      (ptr),
  .cfg_o    (cfg_o),
  .wr_regs  ({dir_o, pol_o, ien_o, cmpv_o, ictl_o, cfg_o, pu_o, olat_o})
);

// File: tb/xp_spi_regs_bench.sv
`timescale 1ns/1ps
module xp_spi_regs_bench;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic [2:0] hw = 3'd5;
  logic [7:0] flag = 8'hA5, cap = 8'h3C, port = 8'h96;
  logic miso, oe;
  logic [7:0] dir, pol, ien, cmpv, ictl, cfg, pu, olat;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m [0:10];
  logic [7:0] wdat [0:15];

  always #4 clk = ~clk;

  xp_spi_regs u_xp_spi_regs (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(oe), .hw_addr_i(hw),
    .flag_i(flag), .cap_i(cap), .port_i(port),
    .dir_o(dir), .pol_o(pol), .ien_o(ien), .cmpv_o(cmpv), .ictl_o(ictl),
    .cfg_o(cfg), .pu_o(pu), .olat_o(olat)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input int i);
    if (i == 7) return flag;
    if (i == 8) return cap;
    if (i == 9) return port;
    if (i > 10) return 8'h00;
    return m[i];
  endfunction

  function automatic int m_nxt(input int p);
    if (m[5][5]) return p;
    return (p >= 10) ? 0 : p + 1;
  endfunction

  task automatic m_wr(input int p, input logic [7:0] d);
    if (p <= 6) m[p] = d;
    else if (p == 9 || p == 10) m[10] = d;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r,
                      output logic oe_all, output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0; r = 8'h00;
    for (int k = 7; k >= 0; k--) begin
      mosi = b[k];
      wait_clk(HALF);
      r[k] = miso;
      oe_all = oe_all & oe;
      oe_any = oe_any | oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " dir"},  dir,  m[0]);
    chk({req, " pol"},  pol,  m[1]);
    chk({req, " ien"},  ien,  m[2]);
    chk({req, " cmpv"}, cmpv, m[3]);
    chk({req, " ictl"}, ictl, m[4]);
    chk({req, " cfg"},  cfg,  m[5]);
    chk({req, " pu"},   pu,   m[6]);
    chk({req, " olat"}, olat, m[10]);
  endtask

  task automatic frame(input string req, input logic [7:0] opc,
                       input logic [7:0] radr, input int n);
    logic acc;
    logic [7:0] r, e;
    logic oa, oy;
    int p, np;
    acc = (opc[7:4] == 4'h4) && (!m[5][3] || (opc[3:1] == hw));
    csn = 1'b0;
    wait_clk(HALF);
    xfer(opc, r, oa, oy);
    chk({req, " R11 oe in opcode"}, {7'b0, oy}, 8'h00);
    xfer(radr, r, oa, oy);
    chk({req, " R11 oe in index"}, {7'b0, oy}, 8'h00);
    if (!acc) begin
      for (int i = 0; i < n; i++) begin
        xfer(wdat[i], r, oa, oy);
        chk({req, " R7 oe rejected"}, {7'b0, oy}, 8'h00);
      end
    end else if (opc[0]) begin
      e = m_rd(int'(radr));
      p = m_nxt(int'(radr));
      for (int i = 0; i < n; i++) begin
        xfer(8'h00, r, oa, oy);
        chk({req, " R3 data"}, r, e);
        chk({req, " R3 oe"}, {7'b0, oa}, 8'h01);
        e = m_rd(p);
        p = m_nxt(p);
      end
    end else begin
      p = int'(radr);
      for (int i = 0; i < n; i++) begin
        xfer(wdat[i], r, oa, oy);
        np = m_nxt(p);
        m_wr(p, wdat[i]);
        p = np;
      end
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(8);
    chk({req, " R11 oe idle"}, {7'b0, oe}, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 11; i++) m[i] = 8'h00;
    m[0] = 8'hFF;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    chk_outs("R1");
    chk("R1 oe", {7'b0, oe}, 8'h00);

    // start index sweep 0..12, address field ignored while matching is off (R6)
    for (int s = 0; s < 13; s++) begin
      for (int k = 0; k < 3; k++) wdat[k] = 8'(s * 29 + k * 13 + 7) & 8'hD7;
      frame("R2 R6 R8 R10", {4'h4, 3'(s), 1'b0}, 8'(s), 3);
      chk_outs("R2");
      frame("R3 R9", {4'h4, 3'(s + 1), 1'b1}, 8'h00, 11);
    end

    // wrap and port alias
    wdat[0] = 8'h55; wdat[1] = 8'h66; wdat[2] = 8'h77; wdat[3] = 8'h88;
    frame("R4 R8", {4'h4, hw, 1'b0}, 8'h09, 4);
    chk_outs("R4");
    frame("R4", {4'h4, hw, 1'b1}, 8'h0A, 3);
    frame("R10", {4'h4, hw, 1'b1}, 8'h0C, 3);

    // pointer held
    wdat[0] = 8'h20;
    frame("R5", {4'h4, hw, 1'b0}, 8'h05, 1);
    chk_outs("R5");
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    frame("R5", {4'h4, hw, 1'b0}, 8'h02, 3);
    chk_outs("R5");
    frame("R5", {4'h4, hw, 1'b1}, 8'h01, 4);
    wdat[0] = 8'h00;
    frame("R5", {4'h4, hw, 1'b0}, 8'h05, 1);
    chk_outs("R5");

    // address matching enabled, all eight addresses
    wdat[0] = 8'h08;
    frame("R6", {4'h4, hw, 1'b0}, 8'h05, 1);
    for (int a = 0; a < 8; a++) begin
      wdat[0] = 8'(8'h10 + a);
      frame("R6", {4'h4, 3'(a), 1'b0}, 8'h06, 1);
      chk_outs("R6");
      frame("R6 R7", {4'h4, 3'(a), 1'b1}, 8'h06, 2);
    end

    // bad prefixes
    wdat[0] = 8'hEE;
    frame("R7", {4'h5, hw, 1'b0}, 8'h00, 1);
    frame("R7", {4'h0, hw, 1'b0}, 8'h01, 1);
    frame("R7", {4'hC, hw, 1'b0}, 8'h02, 1);
    frame("R7", {4'h6, hw, 1'b1}, 8'h00, 2);
    chk_outs("R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule